// File: doc/BRIEF.md
# Program Bank Address Generator

This block maps each CPU access in the upper 32 KB of the address space onto a physical program-ROM bank number at 8 KB granularity. Four windows are served: 0x8000, 0xA000, 0xC000 and 0xE000, selected by CPU address bits 14:13. The bank number for each window has two parts. The low eight bits come from the window's source value, limited by a programmable inner mask. The bits outside that mask come from an outer block. A 4-bit high field extends the outer block above the low byte. With this split one large ROM can hold many smaller images, each of which sees a private bank space.

The registers are loaded through a single CPU write port. An extended register window sits at 0x4100-0x410F. There is also a pair of bank-switch ports in the 0x8000-0xFFFF range: a command port for even addresses and a data port for odd addresses, both decoded under mask 0xE001. The output is combinational from the stored state and the CPU address. A write therefore takes effect on the first access after the clock edge that captures it.

Top module: `prg_bank_gen`

## Requirements
- R1: After reset, which is asynchronous and active low, every stored register is zero. With that state the windows 0x8000/0xA000/0xC000/0xE000 give banks 0x000, 0x000, 0x03E and 0x03F.
- R2: Bits 2:0 of extended register 0xB form the split mode. Mode 7 gives inner mask 0xFF. Every other mode m gives inner mask 0x3F >> m, so mode 6 gives a mask of zero.
- R3: Output bits 11:8 equal bits 7:4 of extended register 0x0. Output bits 7:0 are extended register 0xA ANDed with the inverted mask, ORed with the window's source value ANDed with the mask.
- R4: The 0x8000 window takes its source from register 0x7 and the 0xA000 window from register 0x8. These registers are loaded directly at 0x4107/0x4108. They are also loaded through the data port when command bits 2:0 are 6 or 7 respectively.
- R5: The 0xC000 window takes its source from register 0x9 when bit 6 of register 0xB is 1. Otherwise it uses the constant 0xFE.
- R6: The 0xE000 window always takes its source from the constant 0xFF.
- R7: When command bit 6 is 1, the 0x8000 and 0xC000 windows swap their sources. The 0xA000 and 0xE000 windows are not affected.
- R8: A write to the command port updates command bits 7:6 and 2:0 and keeps bits 5:3. A write to 0x4105 loads the whole command register.
- R9: The following writes leave the output unchanged: extended offsets 1-4, 6 and 0xC-0xF; data-port writes with command bits 2:0 equal to 0-5; writes to 0xA000, 0xC000 and 0xE000-class addresses; and writes outside both decoded ranges.
- R10: The output changes only through the CPU address or through a write captured at a clock edge. A register write is visible right after the edge that samples it and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 8 | Write data |
| cpu_addr_i | input | 16 | Address of the current CPU access |
| bank_o | output | 12 | Physical 8 KB bank number |

## Verification
The bench walks through the split modes at both ends of the range. Mode 6 has an empty inner mask and mode 7 has a full one. A wrong shift or a missing special case for mode 7 would let the outer register leak into the low bits, or hide it. It sets the swap bit with the 0xC000 window held on its fixed 0xFE source. A design that swapped the wrong pair, or also moved 0xA000 or 0xE000, would return a value in the wrong window. It also writes to every IRQ and mirror offset, to the CHR data commands, to neighbouring address classes and to 0x4110. A loose decoder would then corrupt the block, source or high registers, and the output would change.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
  localparam int unsigned PRG_DW    = 8;
  localparam int unsigned PRG_HI_W  = 4;
  localparam int unsigned PRG_BANK_W = PRG_DW + PRG_HI_W;
  localparam int unsigned PRG_WIN_N = 4;

  localparam logic [11:0] EXT_PAGE    = 12'h410;
  localparam logic [7:0]  BASE_MASK   = 8'h3F;
  localparam logic [7:0]  FULL_MASK   = 8'hFF;
  localparam logic [7:0]  PENULT_BANK = 8'hFE;
  localparam logic [7:0]  LAST_BANK   = 8'hFF;
  localparam logic [7:0]  CMD_KEEP    = 8'h38;

  typedef logic [PRG_DW-1:0] prg_byte_t;

  typedef struct packed {
    prg_byte_t blk;     // offset 0x0
    prg_byte_t cmd;     // offset 0x5 / command port
    prg_byte_t src_a;   // offset 0x7
    prg_byte_t src_b;   // offset 0x8
    prg_byte_t src_c;   // offset 0x9
    prg_byte_t hi_fix;  // offset 0xA
    prg_byte_t cfg;     // offset 0xB
  } prg_regs_t;

  typedef enum logic [3:0] {
    OFF_BLK  = 4'h0,
    OFF_CMD  = 4'h5,
    OFF_SRCA = 4'h7,
    OFF_SRCB = 4'h8,
    OFF_SRCC = 4'h9,
    OFF_HFIX = 4'hA,
    OFF_CFG  = 4'hB
  } ext_off_e;
endpackage

// File: rtl/prg_reg_file.sv
module prg_reg_file
  import prg_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  prg_byte_t         wr_data_i,
  output prg_regs_t         regs_o
);
  localparam int unsigned PAGE_LSB = 4;

  prg_regs_t regs_q;
  logic      ext_hit, cmd_hit, dat_hit;
  logic [3:0] off;

  assign off     = wr_addr_i[3:0];
  assign ext_hit = wr_en_i && (wr_addr_i[ADDR_W-1:PAGE_LSB] == EXT_PAGE);
  // mask 0xE001: bit 15 set, bits 14:13 zero, bit 0 picks port
  assign cmd_hit = wr_en_i && wr_addr_i[ADDR_W-1] && (wr_addr_i[ADDR_W-2:ADDR_W-3] == 2'b00)
                   && !wr_addr_i[0];
  assign dat_hit = wr_en_i && wr_addr_i[ADDR_W-1] && (wr_addr_i[ADDR_W-2:ADDR_W-3] == 2'b00)
                   && wr_addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (ext_hit) begin
      case (off)
        OFF_BLK:  regs_q.blk    <= wr_data_i;
        OFF_CMD:  regs_q.cmd    <= wr_data_i;
        OFF_SRCA: regs_q.src_a  <= wr_data_i;
        OFF_SRCB: regs_q.src_b  <= wr_data_i;
        OFF_SRCC: regs_q.src_c  <= wr_data_i;
        OFF_HFIX: regs_q.hi_fix <= wr_data_i;
        OFF_CFG:  regs_q.cfg    <= wr_data_i;
        default:  ; // IRQ, mirror and unused offsets
      endcase
    end else if (cmd_hit) begin
      regs_q.cmd <= (regs_q.cmd & CMD_KEEP) | (wr_data_i & ~CMD_KEEP);
    end else if (dat_hit) begin
      case (regs_q.cmd[2:0])
        3'd6:    regs_q.src_a <= wr_data_i;
        3'd7:    regs_q.src_b <= wr_data_i;
        default: ; // pattern-table selects live elsewhere
      endcase
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/prg_mask_gen.sv
module prg_mask_gen
  import prg_bank_pkg::*;
(
  input  logic [2:0]          mode_i,
  input  logic [PRG_HI_W-1:0] blk_hi_i,
  input  prg_byte_t           hi_fix_i,
  output prg_byte_t           mask_o,
  output logic [PRG_BANK_W-1:0] outer_o
);
  always_comb begin
    if (mode_i == 3'd7) mask_o = FULL_MASK;
    else                mask_o = BASE_MASK >> mode_i;
  end

  assign outer_o = {blk_hi_i, hi_fix_i & ~mask_o};
endmodule

// File: rtl/prg_window_sel.sv
module prg_window_sel
  import prg_bank_pkg::*;
(
  input  prg_byte_t             src_a_i,
  input  prg_byte_t             src_b_i,
  input  prg_byte_t             src_c_i,
  input  logic                  c_sel_i,
  input  logic                  swap_i,
  input  prg_byte_t             mask_i,
  input  logic [PRG_BANK_W-1:0] outer_i,
  input  logic [1:0]            win_i,
  output logic [PRG_BANK_W-1:0] bank_o
);
  prg_byte_t             src [PRG_WIN_N];
  logic [PRG_BANK_W-1:0] bank_w [PRG_WIN_N];

  assign src[0] = src_a_i;
  assign src[1] = src_b_i;
  assign src[2] = c_sel_i ? src_c_i : PENULT_BANK;
  assign src[3] = LAST_BANK;

  for (genvar w = 0; w < PRG_WIN_N; w++) begin : g_win
    // even windows trade places under swap, odd windows stay
    localparam int unsigned PEER = (w % 2 == 0) ? (w ^ 2) : w;
    prg_byte_t inner;
    assign inner     = swap_i ? src[PEER] : src[w];
    assign bank_w[w] = outer_i | {{PRG_HI_W{1'b0}}, inner & mask_i};
  end

  assign bank_o = bank_w[win_i];
endmodule

// File: rtl/prg_bank_gen.sv
module prg_bank_gen
  import prg_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BANK_W = PRG_BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [BANK_W-1:0] bank_o
);
  localparam int unsigned WIN_LSB = 13;

  prg_regs_t             regs_w;
  prg_byte_t             mask_w;
  logic [PRG_BANK_W-1:0] outer_w;
  logic [2:0]            mode_w;
  logic [PRG_HI_W-1:0]   blk_hi_w;
  prg_byte_t             hi_fix_w;
  logic [PRG_BANK_W-1:0] bank_w;

  prg_reg_file #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs_w)
  );

  assign mode_w   = regs_w.cfg[2:0];
  assign blk_hi_w = regs_w.blk[PRG_DW-1 -: PRG_HI_W];
  assign hi_fix_w = regs_w.hi_fix;

  prg_mask_gen u_mask (
    .mode_i   (mode_w),
    .blk_hi_i (blk_hi_w),
    .hi_fix_i (hi_fix_w),
    .mask_o   (mask_w),
    .outer_o  (outer_w)
  );

  prg_window_sel u_win (
    .src_a_i (regs_w.src_a),
    .src_b_i (regs_w.src_b),
    .src_c_i (regs_w.src_c),
    .c_sel_i (regs_w.cfg[6]),
    .swap_i  (regs_w.cmd[6]),
    .mask_i  (mask_w),
    .outer_i (outer_w),
    .win_i   (cpu_addr_i[WIN_LSB+1:WIN_LSB]),
    .bank_o  (bank_w)
  );

  assign bank_o = BANK_W'(bank_w);
endmodule

// File: rtl/prg_bank_chk.sv
module prg_bank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_addr_i,
  input logic [15:0] cpu_addr_i,
  input logic [11:0] bank_o,
  input logic [2:0]  mode_i,
  input logic [3:0]  blk_hi_i,
  input logic [7:0]  hi_fix_i
);
  // R9
  irq_offset_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i[15:4] == 12'h410 && wr_addr_i[3:0] >= 4'd1 && wr_addr_i[3:0] <= 4'd4)
    |=> (!$stable(cpu_addr_i) || $stable(bank_o)));

  // R10
  hold_without_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (!$stable(cpu_addr_i) || $stable(bank_o)));

  // R3
  outer_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_o[11:8] == blk_hi_i);

  // R2
  empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd6) |-> (bank_o[7:0] == hi_fix_i));

  // R6
  last_window_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[14:13] == 2'b11 && mode_i == 3'd7) |-> (bank_o[7:0] == 8'hFF));
endmodule

bind prg_bank_gen prg_bank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .cpu_addr_i (cpu_addr_i),
  .bank_o     (bank_o),
  .mode_i     (mode_w),
  .blk_hi_i   (blk_hi_w),
  .hi_fix_i   (hi_fix_w)
);

// File: tb/sim_prg_bank_gen.sv
`timescale 1ns/1ps
module sim_prg_bank_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [15:0] cpu_addr_i = 16'h8000;
  logic [11:0] bank_o;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prg_bank_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cpu_addr_i(cpu_addr_i), .bank_o(bank_o)
  );

  task automatic chk(input logic [15:0] a, input logic [11:0] exp, input string tag);
    cpu_addr_i = a;
    #1;
    n_vec++;
    if (bank_o !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, bank_o, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(16'h8000, 12'h000, "R1 w0");
    chk(16'hA000, 12'h000, "R1 w1");
    chk(16'hC000, 12'h03E, "R1 w2");
    chk(16'hE000, 12'h03F, "R1 w3");
  endtask

  task automatic t_sources();
    do_reset();
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h15);
    wr(16'h8000, 8'h07); wr(16'h8001, 8'hAA);
    chk(16'h8000, 12'h015, "R4 cmd6");
    chk(16'hBFFF, 12'h02A, "R4 cmd7");
    wr(16'h4107, 8'h07);
    chk(16'h9234, 12'h007, "R4 direct");
    wr(16'h4108, 8'h31);
    chk(16'hA000, 12'h031, "R4 direct b");
  endtask

  task automatic t_ignored();
    do_reset();
    wr(16'h4107, 8'h07); wr(16'h4108, 8'h09);
    for (int c = 0; c < 6; c++) begin
      wr(16'h8000, 8'(c)); wr(16'h8001, 8'h33);
    end
    for (int o = 1; o < 5; o++) wr(16'h4100 | 16'(o), 8'hFF);
    wr(16'h4106, 8'hFF); wr(16'h410C, 8'hFF); wr(16'h410F, 8'hFF);
    wr(16'hA000, 8'h55); wr(16'hC000, 8'h55); wr(16'hE001, 8'h55);
    wr(16'h4110, 8'hF0); wr(16'h4000, 8'hF7); wr(16'h5107, 8'h3C);
    chk(16'h8000, 12'h007, "R9 w0");
    chk(16'hA000, 12'h009, "R9 w1");
    chk(16'hC000, 12'h03E, "R9 w2");
    chk(16'hE000, 12'h03F, "R9 w3");
  endtask

  task automatic t_modes();
    do_reset();
    wr(16'h410A, 8'hC5); wr(16'h4107, 8'h1B);
    chk(16'h8000, 12'h0DB, "R2 mode0");
    chk(16'hE000, 12'h0FF, "R6 mode0");
    wr(16'h410B, 8'h02);
    chk(16'h8000, 12'h0CB, "R2 mode2");
    wr(16'h410B, 8'h03);
    chk(16'h8000, 12'h0C3, "R2 mode3");
    wr(16'h410B, 8'h05);
    chk(16'h8000, 12'h0C5, "R2 mode5");
    wr(16'h410B, 8'h06);
    chk(16'h8000, 12'h0C5, "R2 mode6");
    chk(16'hE000, 12'h0C5, "R6 mode6");
    wr(16'h410B, 8'h07);
    chk(16'h8000, 12'h01B, "R2 mode7");
    chk(16'hE000, 12'h0FF, "R6 mode7");
    chk(16'hC000, 12'h0FE, "R5 mode7 fixed");
  endtask

  task automatic t_outer();
    do_reset();
    wr(16'h410A, 8'hC5); wr(16'h4107, 8'h1B); wr(16'h4100, 8'hA7);
    chk(16'h8000, 12'hADB, "R3 outer");
    chk(16'hE000, 12'hAFF, "R3 outer last");
  endtask

  task automatic t_csel();
    do_reset();
    wr(16'h4109, 8'h12);
    chk(16'hC000, 12'h03E, "R5 fixed");
    wr(16'h410B, 8'h40);
    chk(16'hC000, 12'h012, "R5 reg");
    chk(16'hE000, 12'h03F, "R6 reg mode");
  endtask

  task automatic t_swap();
    do_reset();
    wr(16'h4107, 8'h11); wr(16'h4108, 8'h22);
    wr(16'h8000, 8'h46);
    chk(16'h8000, 12'h03E, "R7 w0");
    chk(16'hC000, 12'h011, "R7 w2");
    chk(16'hA000, 12'h022, "R7 w1");
    chk(16'hE000, 12'h03F, "R7 w3");
    wr(16'h8001, 8'h05);
    chk(16'hC000, 12'h005, "R8 select kept");
    wr(16'h8000, 8'h07);
    chk(16'h8000, 12'h005, "R8 swap cleared");
    wr(16'h4105, 8'h40);
    chk(16'h8000, 12'h03E, "R8 direct cmd");
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 16'h4107; wr_data_i = 8'h2D;
    chk(16'h8000, 12'h000, "R10 before edge");
    @(posedge clk);
    #1;
    wr_en_i = 1'b0;
    chk(16'h8000, 12'h02D, "R10 after edge");
    chk(16'hE000, 12'h03F, "R10 addr only");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sources();
    t_ignored();
    t_modes();
    t_outer();
    t_csel();
    t_swap();
    t_timing();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule